// File: doc/BRIEF.md
# Variable-Rate Circular Audio Delay Controller

This block steers a block-organised circular delay line that lives in an external memory. It keeps two block indices into a ring of 1456 blocks: the block that the recording datapath is filling and the block that the playback datapath is draining. The delay is the distance between them. A longer requested delay needs a larger distance, and once that distance would no longer fit in the ring the recording sample rate is lowered in steps. Each recorded block is tagged with the rate it was captured at, and playback always runs at the tag of the block under the read index. A rate change therefore reaches the output only when the first block captured at the new rate comes up for playback.

The delay request arrives in 50 ms steps. From it the block chooses a recording rate code and a target distance in blocks. Each time the playback datapath finishes a block, the block compares the tracked distance with the target. It then holds the read index, steps it by one, or steps it by two, so the distance drifts toward the target. Two divider counters turn a reference enable into the recording and playback sample ticks. A status flag is high while the recording and playback rates differ, so that an indicator can flash.

Top module: `avd_delay_ctrl`

## Requirements
- R1: After a synchronous active-high reset, rec_blk and play_blk are 0, rec_div and play_div are 1024, and rate_shift is 0.
- R2: Each rec_done pulse advances rec_blk by one on the next clock edge, and index 1455 is followed by 0. Without rec_done, rec_blk holds.
- R3: The rate code is chosen from delay_req (in 50 ms steps). A value of 160 or less gives code 0 with divisor 1024. Values 161 to 240 give code 1 with divisor 1536. Values 241 to 320 give code 2 with divisor 2048. Values above 320 give code 3 with divisor 4096. The recording rate takes the chosen code on each rec_done and holds it otherwise, both when the rate steps down and when it steps back up.
- R4: The target distance is floor(delay_req*K/1024) for the chosen code, clamped to the range 1 to 1455. K is 8333, 5555, 4166 or 2083 for codes 0 to 3.
- R5: The distance is (rec_blk - play_blk) mod 1456. On play_done, play_blk holds if the distance is below the target, advances by one if it equals the target, and advances by two if it is above the target. If rec_done arrives while the distance is 1455 and play_blk would not move, play_blk advances by one and drops the oldest block.
- R6: On rec_done, the current recording rate code is stored as the tag of the block at rec_blk. play_div shows the divisor of the tag of the block at play_blk one edge after play_blk changes, and it tracks later rewrites of that tag.
- R7: rate_shift is 1 exactly when the recording and playback rate codes differ, one edge after they do.
- R8: With ref_tick held high, rec_tick and play_tick are single-cycle pulses spaced rec_div and play_div clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference-rate enable that the dividers count |
| delay_req | input | 10 | Requested delay in 50 ms steps |
| rec_done | input | 1 | Recording datapath finished a block |
| play_done | input | 1 | Playback datapath finished a block |
| rec_blk | output | 11 | Block index being recorded |
| play_blk | output | 11 | Block index being played |
| rec_div | output | 13 | Recording sample divisor |
| play_div | output | 13 | Playback sample divisor |
| rec_tick | output | 1 | Recording sample tick |
| play_tick | output | 1 | Playback sample tick |
| rate_shift | output | 1 | Recording and playback rates differ |

## Verification
Latency is counted in edges for each result:
- rec_blk and rec_div settle on the edge that samples rec_done.
- play_blk settles on the edge that samples play_done.
- play_div settles one edge after play_blk, because the tag memory has a registered read port.
- rate_shift settles one edge after either rate changes.
- A new delay_req reaches the target and rate choice after one edge.

The bench drives and samples on falling edges. Before each check it waits at least that many edges: two after a delay change, and three after a playback or recording pulse whenever play_div or rate_shift is checked. The tick periods are measured between two consecutive pulses, so the check does not depend on the counter phase at the start.

// File: rtl/avd_pkg.sv
package avd_pkg;
  typedef logic [1:0] rate_t;
  localparam rate_t RATE_FULL  = 2'd0;
  localparam rate_t RATE_TWO3  = 2'd1;
  localparam rate_t RATE_HALF  = 2'd2;
  localparam rate_t RATE_QUART = 2'd3;
endpackage

// File: rtl/avd_rate_sel.sv
module avd_rate_sel
  import avd_pkg::*;
#(
  parameter int STEP_W      = 10,
  parameter int IDX_W       = 11,
  parameter int NUM_BLOCKS  = 1456,
  parameter int REF_HZ      = 40_000_000,
  parameter int STEP_MS     = 50,
  parameter int BLK_SAMPLES = 240,
  parameter int DIV0        = 1024,
  parameter int DIV1        = 1536,
  parameter int DIV2        = 2048,
  parameter int DIV3        = 4096,
  parameter int TH1         = 160,
  parameter int TH2         = 240,
  parameter int TH3         = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] delay_req,
  output rate_t             sel_rate,
  output logic [IDX_W-1:0]  target_gap
);
  localparam int KW = 16;
  localparam int PW = STEP_W + KW;
  localparam longint unsigned SCALE = 64'(REF_HZ) * 64'(STEP_MS) * 64'(1024);
  localparam longint unsigned BASE  = 64'(1000) * 64'(BLK_SAMPLES);

  // blocks per delay step, in 1/1024 units, for each rate code
  function automatic logic [KW-1:0] k_of(input rate_t r);
    case (r)
      RATE_FULL: k_of = KW'(SCALE / (BASE * 64'(DIV0)));
      RATE_TWO3: k_of = KW'(SCALE / (BASE * 64'(DIV1)));
      RATE_HALF: k_of = KW'(SCALE / (BASE * 64'(DIV2)));
      default:   k_of = KW'(SCALE / (BASE * 64'(DIV3)));
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] gap_of(input logic [STEP_W-1:0] d, input rate_t r);
    logic [PW-1:0] prod;
    logic [PW-11:0] blocks;
    prod   = PW'(d) * PW'(k_of(r));
    blocks = prod[PW-1:10];
    if (blocks > (PW-10)'(NUM_BLOCKS - 1)) gap_of = IDX_W'(NUM_BLOCKS - 1);
    else if (blocks == '0)                 gap_of = IDX_W'(1);
    else                                   gap_of = blocks[IDX_W-1:0];
  endfunction

  rate_t rate_c;

  always_comb begin
    if (delay_req > STEP_W'(TH3))      rate_c = RATE_QUART;
    else if (delay_req > STEP_W'(TH2)) rate_c = RATE_HALF;
    else if (delay_req > STEP_W'(TH1)) rate_c = RATE_TWO3;
    else                               rate_c = RATE_FULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_rate   <= RATE_FULL;
      target_gap <= IDX_W'(1);
    end else begin
      sel_rate   <= rate_c;
      target_gap <= gap_of(delay_req, rate_c);
    end
  end

  assert_target_range_R4: assert property (@(posedge clk) disable iff (rst)
    (target_gap >= IDX_W'(1)) && (target_gap <= IDX_W'(NUM_BLOCKS - 1)));
endmodule

// File: rtl/avd_tag_ram.sv
module avd_tag_ram #(
  parameter int DEPTH = 1456,
  parameter int AW    = 11,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

  assert_waddr_in_ring_R6: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/avd_tick_div.sv
module avd_tick_div #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (ref_tick) begin
        if (cnt >= div - CNT_W'(1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/avd_delay_ctrl.sv
module avd_delay_ctrl
  import avd_pkg::*;
#(
  parameter int STEP_W      = 10,
  parameter int IDX_W       = 11,
  parameter int NUM_BLOCKS  = 1456,
  parameter int DIV_W       = 13,
  parameter int REF_HZ      = 40_000_000,
  parameter int STEP_MS     = 50,
  parameter int BLK_SAMPLES = 240,
  parameter int DIV0        = 1024,
  parameter int DIV1        = 1536,
  parameter int DIV2        = 2048,
  parameter int DIV3        = 4096,
  parameter int TH1         = 160,
  parameter int TH2         = 240,
  parameter int TH3         = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [STEP_W-1:0] delay_req,
  input  logic              rec_done,
  input  logic              play_done,
  output logic [IDX_W-1:0]  rec_blk,
  output logic [IDX_W-1:0]  play_blk,
  output logic [DIV_W-1:0]  rec_div,
  output logic [DIV_W-1:0]  play_div,
  output logic              rec_tick,
  output logic              play_tick,
  output logic              rate_shift
);
  localparam int LAST = NUM_BLOCKS - 1;

  function automatic logic [DIV_W-1:0] div_of(input rate_t r);
    case (r)
      RATE_FULL: div_of = DIV_W'(DIV0);
      RATE_TWO3: div_of = DIV_W'(DIV1);
      RATE_HALF: div_of = DIV_W'(DIV2);
      default:   div_of = DIV_W'(DIV3);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] x, input logic [1:0] a);
    logic [IDX_W:0] s;
    s = {1'b0, x} + (IDX_W+1)'(a);
    if (s >= (IDX_W+1)'(NUM_BLOCKS)) s = s - (IDX_W+1)'(NUM_BLOCKS);
    ring_add = s[IDX_W-1:0];
  endfunction

  rate_t            sel_rate;
  rate_t            rec_rate;
  rate_t            play_rate;
  logic [IDX_W-1:0] target_gap;
  logic [IDX_W-1:0] gap_r;
  logic [1:0]       adv;

  avd_rate_sel #(
    .STEP_W(STEP_W), .IDX_W(IDX_W), .NUM_BLOCKS(NUM_BLOCKS),
    .REF_HZ(REF_HZ), .STEP_MS(STEP_MS), .BLK_SAMPLES(BLK_SAMPLES),
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3),
    .TH1(TH1), .TH2(TH2), .TH3(TH3)
  ) u_sel (
    .clk(clk), .rst(rst), .delay_req(delay_req),
    .sel_rate(sel_rate), .target_gap(target_gap)
  );

  avd_tag_ram #(.DEPTH(NUM_BLOCKS), .AW(IDX_W), .DW(2)) u_tags (
    .clk(clk), .rst(rst), .we(rec_done), .waddr(rec_blk), .wdata(rec_rate),
    .raddr(play_blk), .rdata(play_rate)
  );

  // playback step: hold, one, or skip one, plus forced step on ring overrun
  always_comb begin
    adv = 2'd0;
    if (play_done) begin
      if (gap_r > target_gap)                        adv = 2'd2;
      else if (gap_r == target_gap && gap_r != '0)   adv = 2'd1;
    end
    if (rec_done && gap_r == IDX_W'(LAST) && adv == 2'd0) adv = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_blk    <= '0;
      play_blk   <= '0;
      gap_r      <= '0;
      rec_rate   <= RATE_FULL;
      rate_shift <= 1'b0;
    end else begin
      if (rec_done) begin
        rec_blk  <= ring_add(rec_blk, 2'd1);
        rec_rate <= sel_rate;
      end
      play_blk   <= ring_add(play_blk, adv);
      gap_r      <= gap_r + IDX_W'(rec_done) - IDX_W'(adv);
      rate_shift <= (rec_rate != play_rate);
    end
  end

  assign rec_div  = div_of(rec_rate);
  assign play_div = div_of(play_rate);

  avd_tick_div #(.CNT_W(DIV_W)) u_rec_tick (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .div(rec_div), .tick(rec_tick)
  );

  avd_tick_div #(.CNT_W(DIV_W)) u_play_tick (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .div(play_div), .tick(play_tick)
  );

  assert_ring_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(rec_blk) < NUM_BLOCKS) && (int'(play_blk) < NUM_BLOCKS));

  assert_rec_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rec_done |=> $stable(rec_blk));

  assert_rate_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rec_done |=> $stable(rec_rate));

  assert_gap_track_R5: assert property (@(posedge clk) disable iff (rst)
    int'(gap_r) == ((int'(rec_blk) + NUM_BLOCKS - int'(play_blk)) % NUM_BLOCKS));

  assert_play_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!play_done && !rec_done) |=> $stable(play_blk));
endmodule

// File: tb/avd_delay_ctrl_test.sv
module avd_delay_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1;
  logic [9:0]  delay_req = '0;
  logic        rec_done = 1'b0;
  logic        play_done = 1'b0;
  logic [10:0] rec_blk, play_blk;
  logic [12:0] rec_div, play_div;
  logic        rec_tick, play_tick, rate_shift;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  avd_delay_ctrl uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .delay_req(delay_req),
    .rec_done(rec_done), .play_done(play_done),
    .rec_blk(rec_blk), .play_blk(play_blk), .rec_div(rec_div), .play_div(play_div),
    .rec_tick(rec_tick), .play_tick(play_tick), .rate_shift(rate_shift)
  );

  // R3 vectors: delay step value and divisor expected after one rec_done
  localparam int NV = 9;
  localparam int V_STEPS [NV] = '{0, 160, 161, 240, 241, 320, 321, 716, 100};
  localparam int V_DIV   [NV] = '{1024, 1024, 1536, 1536, 2048, 2048, 4096, 4096, 1024};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_rec(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rec_done = 1'b1;
      @(negedge clk) rec_done = 1'b0;
    end
  endtask

  task automatic pulse_play();
    @(negedge clk) play_done = 1'b1;
    @(negedge clk) play_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    delay_req = '0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic tick_period(input bit use_play, output int period);
    int guard;
    guard = 0;
    while (((use_play ? play_tick : rec_tick) !== 1'b1) && guard < 10000) begin
      @(negedge clk); guard++;
    end
    period = 0;
    do begin
      @(negedge clk); period++;
    end while (((use_play ? play_tick : rec_tick) !== 1'b1) && period < 10000);
  endtask

  initial begin
    int per;
    do_reset();
    // R1 reset state
    chk("R1 rec_blk", int'(rec_blk), 0);
    chk("R1 play_blk", int'(play_blk), 0);
    chk("R1 rec_div", int'(rec_div), 1024);
    chk("R1 play_div", int'(play_div), 1024);
    chk("R1 rate_shift", int'(rate_shift), 0);

    // R3 table walk, R2 increments
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) delay_req = 10'(V_STEPS[i]);
      cyc(2);
      pulse_rec(1);
      chk($sformatf("R3 div for steps %0d", V_STEPS[i]), int'(rec_div), V_DIV[i]);
      chk("R2 rec_blk step", int'(rec_blk), i + 1);
    end
    cyc(2);
    chk("R3 rate holds without rec_done", int'(rec_div), 1024);

    // R2 wrap and R5 overrun push
    pulse_rec(1455 - NV);
    chk("R2 rec_blk at last", int'(rec_blk), 1455);
    chk("R5 play held before overrun", int'(play_blk), 0);
    pulse_rec(1);
    chk("R2 rec_blk wraps", int'(rec_blk), 0);
    chk("R5 overrun drops oldest", int'(play_blk), 1);

    // R4/R5 gap regulation
    do_reset();
    delay_req = 10'd4;                 // code 0, target 32
    cyc(2);
    pulse_play();
    chk("R5 pause at gap 0", int'(play_blk), 0);
    pulse_rec(32);
    pulse_play();
    chk("R4 target 32 step one", int'(play_blk), 1);
    pulse_rec(2);                      // gap 33
    pulse_play();
    chk("R5 skip above target", int'(play_blk), 3);
    pulse_play();                      // gap 31
    chk("R5 pause below target", int'(play_blk), 3);
    @(negedge clk) delay_req = 10'd200; // code 1, target 1084
    cyc(2);
    pulse_rec(1052);                   // gap 1083
    pulse_play();
    chk("R4 code1 gap 1083 holds", int'(play_blk), 3);
    pulse_rec(1);                      // gap 1084
    pulse_play();
    chk("R4 code1 target 1084", int'(play_blk), 4);
    @(negedge clk) delay_req = 10'd716; // code 3, clamped to 1455
    cyc(2);
    pulse_rec(372);                    // gap 1455
    pulse_play();
    chk("R4 clamp to 1455", int'(play_blk), 5);
    @(negedge clk) delay_req = 10'd0;  // target clamped to 1
    cyc(2);
    pulse_play();                      // gap 1454 > 1
    chk("R4 clamp to 1 skip", int'(play_blk), 7);

    // R6/R7 tags and status flag
    do_reset();
    delay_req = 10'd200;
    cyc(2);
    pulse_rec(3);                      // tags: 0,1,1
    cyc(3);
    chk("R3 rec_div stepped down", int'(rec_div), 1536);
    chk("R6 play_div old tag", int'(play_div), 1024);
    chk("R7 flag rates differ", int'(rate_shift), 1);
    @(negedge clk) delay_req = 10'd0;
    cyc(2);
    pulse_play();
    cyc(3);
    chk("R5 skip to block 2", int'(play_blk), 2);
    chk("R6 play_div from tag", int'(play_div), 1536);
    chk("R7 flag clears", int'(rate_shift), 0);
    pulse_play();
    cyc(3);
    chk("R6 unwritten tag", int'(play_div), 1024);
    chk("R7 flag sets", int'(rate_shift), 1);
    pulse_rec(1);
    cyc(3);
    chk("R3 rec_div steps up", int'(rec_div), 1024);
    chk("R6 tag rewrite seen", int'(play_div), 1536);
    chk("R7 flag after swap", int'(rate_shift), 1);

    // R8 tick spacing
    tick_period(1'b0, per);
    chk("R8 rec tick period", per, 1024);
    tick_period(1'b1, per);
    chk("R8 play tick period", per, 1536);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(10ns * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule